// File: doc/BRIEF.md
# Load-to-load ordering violation queue

This block keeps a small associative record of loads that have already read their data. That record lets the core detect one hazard: two loads to the same location ran out of program order, and between them another agent took the cache line away. Each record holds a 16-bit compressed physical address, a sequence number used as an age tag, and a released flag. The released flag is set when the data cache gives up the line. Non-cacheable loads have the flag set from the start.

A load in the address-check stage of the load pipeline presents one request to the queue. The request carries its compressed address, its sequence number and its enqueue conditions. In the cycle of the handshake the queue searches for younger recorded loads to the same address whose line has been released. One cycle later it returns a response with a replay flag, and the core uses that flag to flush every instruction after the querying load. In the same handshake cycle the load may also be written into a free slot chosen by an internal free list. Slots are freed when their loads commit or when a redirect flush squashes them.

Top module: `ldld_order_queue`

## Requirements
- R1: After reset the queue is empty: `req_ready` is 1, `resp_valid` is 0 and `resp_replay` is 0.
- R2: A load is written into the queue only when the handshake completes (`req_valid` and `req_ready` both 1), `req_need_enq` is 1 and `req_flush` is 0. A request that fails any of these leaves no record, so a later query never hits on it.
- R3: `req_ready` is 0 exactly when all ENTRIES slots hold a record. A slot freed by commit or flush is available again from the following cycle.
- R4: A load enqueued with `req_noncache` = 1 is stored with its released flag already set.
- R5: A pulse on `rel_valid` sets the released flag of every stored record whose address equals `rel_addr`. Records with any other address keep their flag.
- R6: A query hits only on records that are strictly younger than the querier. Younger means `(rec_seq - req_seq) mod 2^SEQ_W` is non-zero and has its top bit clear. Equal or older records never hit.
- R7: A query hits only on records whose 16-bit address equals `req_addr` in every bit.
- R8: `resp_valid` is 1 in the cycle after a completed handshake and 0 in every other cycle. `resp_replay` is 1 only together with `resp_valid`, and only when at least one stored record was allocated, younger, address-equal and released in the handshake cycle.
- R9: When `commit_valid` is 1, every stored record that is not younger than `commit_seq` is removed. From the next cycle on it no longer hits.
- R10: When `flush_valid` is 1, every stored record strictly younger than `flush_seq` is removed. From the next cycle on it no longer hits. Records equal to or older than `flush_seq` remain.
- R11: If a release for an address and an enqueue of a load to that same address happen in the same cycle, the new record is stored released.
- R12: The age comparison works across the wrap of the sequence number. With SEQ_W = 6, a record with sequence 1 is younger than a querier with 62 and older than a querier with 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Queue has a free slot |
| req_addr | input | 16 | Compressed physical address of the load |
| req_seq | input | SEQ_W | Sequence number (age tag) of the load |
| req_need_enq | input | 1 | An older load is still unfinished |
| req_flush | input | 1 | This load is being squashed |
| req_noncache | input | 1 | Load is non-cacheable |
| resp_valid | output | 1 | Query response, one cycle after handshake |
| resp_replay | output | 1 | Violation found: replay from fetch |
| rel_valid | input | 1 | Cache line released (eviction, probe or atomic miss) |
| rel_addr | input | 16 | Compressed address of the released line |
| commit_valid | input | 1 | Loads up to `commit_seq` have committed |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| flush_valid | input | 1 | Redirect flush |
| flush_seq | input | SEQ_W | Records younger than this are squashed |

## Verification
The bench checks the age boundary from both sides. An equal sequence number must not hit, a younger one must hit, and a wrap case must be ordered correctly; a design that compared raw magnitudes would either miss the hazard or replay the wrong load. It checks that releases and non-cacheable enqueues set the flag on the right records only, including a release that arrives in the same cycle as the enqueue it must cover, and that a single differing address bit prevents a hit. It fills the queue to check back-pressure, and removes records by commit and by flush to show they stop hitting at once. It also drives requests that must not enqueue, so that a design that recorded a flushed or independent load would later raise a false replay.

// File: rtl/ldld_pkg.sv
package ldld_pkg;
  localparam int CPADDR_W = 16;
  typedef logic [CPADDR_W-1:0] cpaddr_t;
endpackage

// File: rtl/ldld_free_list.sv
module ldld_free_list #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic [ENTRIES-1:0] give_back,
  output logic               avail,
  output logic [IDX_W-1:0]   slot
);
  logic [ENTRIES-1:0] free_q;
  logic [ENTRIES-1:0] take_mask;

  // lowest free index wins
  always_comb begin
    slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_q[i]) slot = IDX_W'(i);
    end
  end

  assign avail = |free_q;

  always_comb begin
    take_mask = '0;
    if (take) take_mask[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= (free_q & ~take_mask) | give_back;
  end
endmodule

// File: rtl/ldld_entry_array.sv
module ldld_entry_array
  import ldld_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 6,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_slot,
  input  cpaddr_t            wr_addr,
  input  logic [SEQ_W-1:0]   wr_seq,
  input  logic               wr_rel,
  input  logic               rel_valid,
  input  cpaddr_t            rel_addr,
  input  logic               commit_valid,
  input  logic [SEQ_W-1:0]   commit_seq,
  input  logic               flush_valid,
  input  logic [SEQ_W-1:0]   flush_seq,
  input  cpaddr_t            q_addr,
  input  logic [SEQ_W-1:0]   q_seq,
  output logic [ENTRIES-1:0] hit_mask,
  output logic [ENTRIES-1:0] freed,
  output logic [ENTRIES-1:0] vld,
  output logic [ENTRIES-1:0] rel
);
  // a strictly younger than b, wrap aware
  function automatic logic younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    cpaddr_t          addr_q;
    logic [SEQ_W-1:0] seq_q;
    logic             vld_q;
    logic             rel_q;
    logic             we;
    logic             kill;

    assign we   = wr_en && (wr_slot == IDX_W'(i));
    assign kill = vld_q && ((commit_valid && !younger(seq_q, commit_seq)) ||
                            (flush_valid && younger(seq_q, flush_seq)));

    always_ff @(posedge clk) begin
      if (we) begin
        addr_q <= wr_addr;
        seq_q  <= wr_seq;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        rel_q <= 1'b0;
      end else if (we) begin
        vld_q <= 1'b1;
        rel_q <= wr_rel;
      end else begin
        if (kill) vld_q <= 1'b0;
        if (rel_valid && vld_q && (addr_q == rel_addr)) rel_q <= 1'b1;
      end
    end

    assign hit_mask[i] = vld_q && rel_q && (addr_q == q_addr) && younger(seq_q, q_seq);
    assign freed[i]    = kill;
    assign vld[i]      = vld_q;
    assign rel[i]      = rel_q;
  end
endmodule

// File: rtl/ldld_order_queue.sv
module ldld_order_queue
  import ldld_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 6,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_addr,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             req_need_enq,
  input  logic             req_flush,
  input  logic             req_noncache,
  output logic             resp_valid,
  output logic             resp_replay,
  input  logic             rel_valid,
  input  logic [15:0]      rel_addr,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             flush_valid,
  input  logic [SEQ_W-1:0] flush_seq
);
  logic               fire;
  logic               do_alloc;
  logic               avail;
  logic [IDX_W-1:0]   alloc_slot;
  logic               wr_rel;
  logic [ENTRIES-1:0] hit_mask;
  logic [ENTRIES-1:0] freed;
  logic [ENTRIES-1:0] ent_vld;
  logic [ENTRIES-1:0] ent_rel;

  assign req_ready = avail;
  assign fire      = req_valid && req_ready;
  assign do_alloc  = fire && req_need_enq && !req_flush;
  assign wr_rel    = req_noncache || (rel_valid && (rel_addr == req_addr));

  ldld_free_list #(.ENTRIES(ENTRIES)) u_free (
    .clk       (clk),
    .rst       (rst),
    .take      (do_alloc),
    .give_back (freed),
    .avail     (avail),
    .slot      (alloc_slot)
  );

  ldld_entry_array #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_arr (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (do_alloc),
    .wr_slot      (alloc_slot),
    .wr_addr      (cpaddr_t'(req_addr)),
    .wr_seq       (req_seq),
    .wr_rel       (wr_rel),
    .rel_valid    (rel_valid),
    .rel_addr     (cpaddr_t'(rel_addr)),
    .commit_valid (commit_valid),
    .commit_seq   (commit_seq),
    .flush_valid  (flush_valid),
    .flush_seq    (flush_seq),
    .q_addr       (cpaddr_t'(req_addr)),
    .q_seq        (req_seq),
    .hit_mask     (hit_mask),
    .freed        (freed),
    .vld          (ent_vld),
    .rel          (ent_rel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_replay <= 1'b0;
    end else begin
      resp_valid  <= fire;
      resp_replay <= fire && (|hit_mask);
    end
  end
endmodule

// File: rtl/ldld_order_queue_chk.sv
module ldld_order_queue_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_need_enq,
  input logic               req_flush,
  input logic               req_noncache,
  input logic               resp_valid,
  input logic               resp_replay,
  input logic               alloc,
  input logic [IDX_W-1:0]   slot,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] rel
);
  assert_resp_after_req_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid);
  assert_no_stray_resp_R8: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !resp_valid);
  assert_replay_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
    resp_replay |-> resp_valid);
  assert_ready_only_full_R3: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> ($countones(vld) == ENTRIES));
  assert_alloc_free_slot_R3: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !vld[slot]);
  assert_alloc_cond_R2: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (req_valid && req_need_enq && !req_flush));
  assert_nc_released_R4: assert property (@(posedge clk) disable iff (rst)
    (alloc && req_noncache) |=> (vld[$past(slot)] && rel[$past(slot)]));
endmodule

bind ldld_order_queue ldld_order_queue_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_need_enq (req_need_enq),
  .req_flush    (req_flush),
  .req_noncache (req_noncache),
  .resp_valid   (resp_valid),
  .resp_replay  (resp_replay),
  .alloc        (do_alloc),
  .slot         (alloc_slot),
  .vld          (ent_vld),
  .rel          (ent_rel)
);

// File: tb/tb_ldld_order_queue.sv
`timescale 1ns/1ps
module tb_ldld_order_queue;
  localparam int ENTRIES = 16;
  localparam int SEQ_W   = 6;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, req_need_enq = 0, req_flush = 0, req_noncache = 0;
  logic [15:0] req_addr = 0, rel_addr = 0;
  logic [SEQ_W-1:0] req_seq = 0, commit_seq = 0, flush_seq = 0;
  logic resp_valid, resp_replay, rel_valid = 0, commit_valid = 0, flush_valid = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ldld_order_queue #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) dut (.*);

  // vector: {op[2:0], addr[15:0], seq[5:0], noncache, expected replay}
  // op 0 query+enqueue, 1 query only, 2 release, 3 commit, 4 flush,
  // 5 query+enqueue with same-address release, 6 query+enqueue while flushed
  localparam int NV = 27;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 16'h1234, 6'd10, 1'b0, 1'b0},  // R2 enqueue A@10
    {3'd0, 16'h1234, 6'd12, 1'b0, 1'b0},  // R6 older entry only
    {3'd1, 16'h1234, 6'd8,  1'b0, 1'b0},  // R5 not yet released
    {3'd2, 16'h5555, 6'd0,  1'b0, 1'b0},  // R5 release other line
    {3'd1, 16'h1234, 6'd8,  1'b0, 1'b0},  // R5 still clean
    {3'd2, 16'h1234, 6'd0,  1'b0, 1'b0},  // R5 release A
    {3'd1, 16'h1234, 6'd8,  1'b0, 1'b1},  // R5 hit
    {3'd1, 16'h1234, 6'd12, 1'b0, 1'b0},  // R6 equal seq no hit
    {3'd1, 16'h1234, 6'd11, 1'b0, 1'b1},  // R6 younger hit
    {3'd1, 16'h1235, 6'd8,  1'b0, 1'b0},  // R7 one bit off
    {3'd0, 16'h0F0F, 6'd20, 1'b1, 1'b0},  // R4 nc enqueue
    {3'd1, 16'h0F0F, 6'd19, 1'b0, 1'b1},  // R4 nc hit
    {3'd5, 16'h0AAA, 6'd21, 1'b0, 1'b0},  // R11 enqueue with release
    {3'd1, 16'h0AAA, 6'd15, 1'b0, 1'b1},  // R11 hit
    {3'd3, 16'h0000, 6'd12, 1'b0, 1'b0},  // R9 commit up to 12
    {3'd1, 16'h1234, 6'd8,  1'b0, 1'b0},  // R9 freed
    {3'd1, 16'h0F0F, 6'd19, 1'b0, 1'b1},  // R9 younger kept
    {3'd4, 16'h0000, 6'd20, 1'b0, 1'b0},  // R10 flush after 20
    {3'd1, 16'h0AAA, 6'd15, 1'b0, 1'b0},  // R10 squashed
    {3'd1, 16'h0F0F, 6'd19, 1'b0, 1'b1},  // R10 equal kept
    {3'd0, 16'h7777, 6'd1,  1'b1, 1'b0},  // R12 enqueue E@1 nc
    {3'd1, 16'h7777, 6'd62, 1'b0, 1'b1},  // R12 wrap younger
    {3'd1, 16'h7777, 6'd3,  1'b0, 1'b0},  // R12 older
    {3'd6, 16'h3333, 6'd40, 1'b1, 1'b0},  // R2 flushed load
    {3'd1, 16'h3333, 6'd39, 1'b0, 1'b0},  // R2 not recorded
    {3'd1, 16'h4444, 6'd41, 1'b1, 1'b0},  // R2 need_enq low
    {3'd1, 16'h4444, 6'd39, 1'b0, 1'b0}   // R2 not recorded
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_need_enq = 0; req_flush = 0; req_noncache = 0;
    rel_valid = 0; commit_valid = 0; flush_valid = 0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 ready", req_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 resp_replay", resp_replay, 0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic exp;
      op  = VEC[v][26:24];
      exp = VEC[v][0];
      idle();
      case (op)
        3'd2: begin rel_valid = 1; rel_addr = VEC[v][23:8]; end
        3'd3: begin commit_valid = 1; commit_seq = VEC[v][7:2]; end
        3'd4: begin flush_valid = 1; flush_seq = VEC[v][7:2]; end
        default: begin
          req_valid    = 1;
          req_addr     = VEC[v][23:8];
          req_seq      = VEC[v][7:2];
          req_noncache = VEC[v][1];
          req_need_enq = (op != 3'd1);
          req_flush    = (op == 3'd6);
          if (op == 3'd5) begin rel_valid = 1; rel_addr = VEC[v][23:8]; end
        end
      endcase
      @(posedge clk);
      @(negedge clk);
      if (op == 3'd2 || op == 3'd3 || op == 3'd4) begin
        chk($sformatf("R8 no resp vec %0d", v), resp_valid, 0);
      end else begin
        chk($sformatf("R8 resp_valid vec %0d", v), resp_valid, 1);
        chk($sformatf("R5-R12 replay vec %0d", v), resp_replay, exp);
      end
    end
    idle();

    // fill test
    do_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      req_valid = 1; req_need_enq = 1;
      req_addr = 16'h0100 + 16'(i); req_seq = SEQ_W'(i);
      @(posedge clk);
      @(negedge clk);
    end
    idle();
    chk("R3 ready low when full", req_ready, 0);
    req_valid = 1; req_addr = 16'h010F; req_seq = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R3 R8 no handshake when full", resp_valid, 0);
    idle();
    commit_valid = 1; commit_seq = 0;
    @(posedge clk);
    @(negedge clk);
    idle();
    chk("R3 ready after commit", req_ready, 1);
    rel_valid = 1; rel_addr = 16'h010F;
    @(posedge clk);
    @(negedge clk);
    idle();
    req_valid = 1; req_addr = 16'h010F; req_seq = 6'd3;
    @(posedge clk);
    @(negedge clk);
    idle();
    chk("R5 last slot hit valid", resp_valid, 1);
    chk("R5 last slot hit replay", resp_replay, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R8 replay low when idle", resp_replay, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule